// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block keeps a pending flag and an active flag for each of a parameterized number of interrupt sources. Together the two flags give each source one of four states: inactive, pending, active, or active-and-pending. A source becomes pending from a hardware request line, from a write-one-to-set register, or from a software trigger register that takes an interrupt ID. Of the enabled pending sources, the block picks the one with the most urgent priority and presents it to the core. It also decides whether that source may preempt the handler now running.

Each priority value is split into a group part and a subpriority part. A programmable grouping field sets the split point. Only the group part takes part in the preemption decision. The core reports that it has taken an exception by giving the vector number. It reports an exception return with a single pulse, which retires the handler now running. Several handlers may be active at once, and the block reports which one is running, how many are nested, and the most urgent pending vector.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every source is inactive and every enable and priority is 0. The grouping field and the unprivileged-trigger permission are 0. The status word (address 4) reads 0x0002_0000, which means only the return-to-base bit 17 is set, and `irq_req` is low.
- R2: A high level on `irq_in[i]` during a clock edge makes source i pending. The pending state stays after the input drops. Pending bits read at address 1 and at address 2, bit i.
- R3: Writing address 1 sets the pending bits whose data bits are 1. Writing address 2 clears them. When a set request (from the bus or from hardware) and a clear request reach the same source in the same cycle, the set wins.
- R4: Writing an ID in bits [7:0] of address 6 sets the pending bit of that source when the ID is below the source count. IDs from the source count up to 255 change nothing. Address 6 reads 0.
- R5: A software trigger write with `bus_priv` low is ignored unless the permission bit 8 of the configuration register (address 5) is 1. Writes with `bus_priv` high are always accepted.
- R6: `irq_vec` and status bits [15:8] give the vector of the most urgent enabled pending source, which is source index + 16. A lower priority value is more urgent, and on equal values the lower index wins. Disabled sources are skipped, and the value is 0 when no enabled source is pending. Enables are at address 5-independent address 0; priorities are at address 32+i, bits [2:0].
- R7: The any-pending flag (status bit 16) is 1 when any pending bit is set, whether or not that source is enabled.
- R8: The group value of a priority is that priority with its low g bits cleared, where g is configuration bits [2:0], limited to the priority width. `irq_req` (also status bit 18) is 1 exactly when an enabled source is pending and either no handler is active or the winner's group value is numerically below the running handler's group value.
- R9: An `exc_take` pulse with vector v makes source v-16 active and clears its pending bit. A request for that source in the same cycle leaves it active-and-pending.
- R10: The active bits read at address 3. Status bits [7:0] give the vector of the most urgent active source (priority value, then lower index), or 0 when none is active. Every nested handler stays active until it returns.
- R11: An `exc_ret` pulse clears the active bit of the running source. The running vector then falls back to the next most urgent active source.
- R12: Return-to-base (status bit 17) is 1 when at most one source is active, and 0 when preempted handlers remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_IRQ | Hardware request per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Write is privileged |
| bus_rdata | output | 32 | Read data for bus_addr |
| exc_take | input | 1 | Core has taken an exception |
| exc_take_vec | input | 8 | Vector number taken |
| exc_ret | input | 1 | Core returns from the running handler |
| irq_req | output | 1 | Winner may preempt now |
| irq_vec | output | 8 | Most urgent enabled pending vector |

## Verification
The bench uses the defaults: eight sources, three priority bits, vectors starting at 16. With three priority bits, every pair of priority values for two sources can be swept under every grouping value from 0 to 3. Both the pending-winner choice and the group-only preemption decision are therefore checked over their whole space, including ties and the setting where no group bits remain. Eight sources are enough to nest three handlers and to send out-of-range trigger IDs.

// File: rtl/irqc_pkg.sv
// Package: shared constants for the nested interrupt controller.
// Assumes word-addressed registers; the priority block sits in the upper half of the address space.
package irqc_pkg;
    localparam int VEC_W     = 8;
    localparam int A_ENABLE  = 0;
    localparam int A_PSET    = 1;
    localparam int A_PCLR    = 2;
    localparam int A_ACTIVE  = 3;
    localparam int A_STATUS  = 4;
    localparam int A_CONFIG  = 5;
    localparam int A_TRIGGER = 6;
    localparam int CFG_ALLOW_BIT = 8;
endpackage

// File: rtl/irqc_source.sv
// Module: per-source pending/active state pair.
// Assumes set/clear/take/return are single-cycle requests already decoded for this source.
module irqc_source (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic take_req,
    input  logic ret_req,
    output logic pend,
    output logic act
);
    // Pending: a set wins over a clear or a take in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend <= 1'b0;
        else if (set_req)            pend <= 1'b1;
        else if (clr_req || take_req) pend <= 1'b0;
    end

    // Active: set on entry, cleared on return of this source.
    always_ff @(posedge clk) begin
        if (!rst_n)        act <= 1'b0;
        else if (take_req) act <= 1'b1;
        else if (ret_req)  act <= 1'b0;
    end

    a_r9_take_activates: assert property (@(posedge clk) disable iff (!rst_n)
        take_req |=> act);
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && clr_req) |=> pend);
endmodule

// File: rtl/irqc_select.sv
// Module: picks the most urgent candidate: lowest priority value, ties to the lowest index.
// Assumes N >= 2; purely combinational.
module irqc_select #(
    parameter int N  = 8,
    parameter int PW = 3,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]    cand,
    input  logic [N*PW-1:0] prio_flat,
    output logic            found,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);
    // Linear scan; a strict compare keeps the lower index on equal priority.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = 0; i < N; i++) begin
            if (cand[i] && (!found || prio_flat[i*PW +: PW] < win_prio)) begin
                found    = 1'b1;
                win_idx  = IW'(i);
                win_prio = prio_flat[i*PW +: PW];
            end
        end
    end
endmodule

// File: rtl/irqc_regs.sv
// Module: register file: enables, priorities, grouping/permission config,
// pending set/clear and software trigger decode, and the read mux.
// Assumes N <= 32 and N <= 2**(ADDR_W-1) so all priority slots are addressable.
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int N      = 8,
    parameter int PW     = 3,
    parameter int ADDR_W = 6,
    localparam int PRIO_BASE = 1 << (ADDR_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_priv,
    input  logic [N-1:0]      pend,
    input  logic [N-1:0]      act,
    input  logic [31:0]       status,
    output logic [31:0]       bus_rdata,
    output logic [N-1:0]      en,
    output logic [N*PW-1:0]   prio_flat,
    output logic [2:0]        grp_cfg,
    output logic              allow_unpriv,
    output logic [N-1:0]      sw_set,
    output logic [N-1:0]      sw_clr
);
    logic trig_ok;

    // Configuration storage written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en           <= '0;
            prio_flat    <= '0;
            grp_cfg      <= '0;
            allow_unpriv <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(A_ENABLE)) en <= bus_wdata[N-1:0];
            if (bus_addr == ADDR_W'(A_CONFIG)) begin
                grp_cfg      <= bus_wdata[2:0];
                allow_unpriv <= bus_wdata[CFG_ALLOW_BIT];
            end
            for (int i = 0; i < N; i++)
                if (bus_addr == ADDR_W'(PRIO_BASE + i))
                    prio_flat[i*PW +: PW] <= bus_wdata[PW-1:0];
        end
    end

    // Trigger is accepted from privileged writers, or from anyone once permitted.
    assign trig_ok = bus_wr && (bus_addr == ADDR_W'(A_TRIGGER)) && (bus_priv || allow_unpriv);

    // Per-source set and clear requests from the bus.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            sw_set[i] = (bus_wr && bus_addr == ADDR_W'(A_PSET) && bus_wdata[i])
                      || (trig_ok && bus_wdata[7:0] == 8'(i));
            sw_clr[i] = bus_wr && bus_addr == ADDR_W'(A_PCLR) && bus_wdata[i];
        end
    end

    // Read mux; the trigger register and unmapped addresses read zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_ENABLE): bus_rdata[N-1:0] = en;
            ADDR_W'(A_PSET),
            ADDR_W'(A_PCLR):   bus_rdata[N-1:0] = pend;
            ADDR_W'(A_ACTIVE): bus_rdata[N-1:0] = act;
            ADDR_W'(A_STATUS): bus_rdata = status;
            ADDR_W'(A_CONFIG): begin
                bus_rdata[2:0]           = grp_cfg;
                bus_rdata[CFG_ALLOW_BIT] = allow_unpriv;
            end
            default: begin
                for (int i = 0; i < N; i++)
                    if (bus_addr == ADDR_W'(PRIO_BASE + i))
                        bus_rdata[PW-1:0] = prio_flat[i*PW +: PW];
            end
        endcase
    end

    a_r5_unpriv_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_TRIGGER) && !bus_priv && !allow_unpriv)
        |-> !trig_ok);
endmodule

// File: rtl/irq_nest_ctrl.sv
// Module: top of the nested interrupt controller. Tracks per-source state,
// selects the pending winner and the running handler, and decides preemption.
// Assumes the core only takes vectors of existing sources and returns in nesting order.
module irq_nest_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ   = 8,
    parameter int PRIO_BITS = 3,
    parameter int ADDR_W    = 6,
    parameter int VEC_BASE  = 16,
    localparam int IW = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic               bus_priv,
    output logic [31:0]        bus_rdata,
    input  logic               exc_take,
    input  logic [VEC_W-1:0]   exc_take_vec,
    input  logic               exc_ret,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    logic [NUM_IRQ-1:0]           pend, act, en, sw_set, sw_clr, take_v, ret_v;
    logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat;
    logic [2:0]                   grp_cfg;
    logic                         allow_unpriv;
    logic                         pend_found, act_found, ret_base;
    logic [IW-1:0]                pend_idx, act_idx;
    logic [PRIO_BITS-1:0]         pend_prio, act_prio, gmask;
    logic [VEC_W-1:0]             act_vec;
    logic [31:0]                  status;

    irqc_regs #(.N(NUM_IRQ), .PW(PRIO_BITS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_priv(bus_priv), .pend(pend), .act(act),
        .status(status), .bus_rdata(bus_rdata), .en(en), .prio_flat(prio_flat),
        .grp_cfg(grp_cfg), .allow_unpriv(allow_unpriv), .sw_set(sw_set), .sw_clr(sw_clr)
    );

    // Decode core entry and return into per-source strobes.
    always_comb begin
        for (int i = 0; i < NUM_IRQ; i++) begin
            take_v[i] = exc_take && (exc_take_vec == VEC_W'(i + VEC_BASE));
            ret_v[i]  = exc_ret && act_found && (act_idx == IW'(i));
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        irqc_source u_src (
            .clk(clk), .rst_n(rst_n),
            .set_req(irq_in[g] || sw_set[g]), .clr_req(sw_clr[g]),
            .take_req(take_v[g]), .ret_req(ret_v[g]),
            .pend(pend[g]), .act(act[g])
        );
    end

    irqc_select #(.N(NUM_IRQ), .PW(PRIO_BITS)) u_sel_pend (
        .cand(pend & en), .prio_flat(prio_flat),
        .found(pend_found), .win_idx(pend_idx), .win_prio(pend_prio)
    );

    irqc_select #(.N(NUM_IRQ), .PW(PRIO_BITS)) u_sel_act (
        .cand(act), .prio_flat(prio_flat),
        .found(act_found), .win_idx(act_idx), .win_prio(act_prio)
    );

    // Group mask: the low grp_cfg bits (capped at the width) are subpriority.
    always_comb begin
        gmask = '1;
        for (int i = 0; i < PRIO_BITS; i++)
            if (i < int'(grp_cfg)) gmask[i] = 1'b0;
    end

    // Preemption: strictly more urgent group than the running handler.
    assign irq_req = pend_found && (!act_found || ((pend_prio & gmask) < (act_prio & gmask)));

    // Vector numbers and the status word.
    assign irq_vec  = pend_found ? VEC_W'(pend_idx) + VEC_W'(VEC_BASE) : '0;
    assign act_vec  = act_found  ? VEC_W'(act_idx)  + VEC_W'(VEC_BASE) : '0;
    assign ret_base = ($countones(act) <= 1);
    assign status   = {13'b0, irq_req, ret_base, |pend, irq_vec, act_vec};

    a_r10_actvec_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (act_vec == '0) == (act == '0));
    a_r8_req_has_vec: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec != '0));
    a_r11_ret_pops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_ret && !exc_take && act != '0)
        |=> ($countones(act) + 1 == $countones($past(act))));
endmodule

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
    localparam int N = 8;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_priv = 1'b1;
    logic [31:0] bus_rdata;
    logic        exc_take = 1'b0;
    logic [7:0]  exc_take_vec = '0;
    logic        exc_ret = 1'b0;
    logic        irq_req;
    logic [7:0]  irq_vec;
    int errors = 0;
    int checks = 0;
    logic [31:0] d;

    irq_nest_ctrl uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_priv(bus_priv),
        .bus_rdata(bus_rdata), .exc_take(exc_take), .exc_take_vec(exc_take_vec),
        .exc_ret(exc_ret), .irq_req(irq_req), .irq_vec(irq_vec)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act_v, input logic [31:0] exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act_v, exp_v);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v, input logic priv = 1'b1);
        @(negedge clk);
        bus_addr = 6'(a); bus_wdata = v; bus_priv = priv; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_priv = 1'b1;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = 6'(a);
        #1 v = bus_rdata;
    endtask

    task automatic take(input int v);
        @(negedge clk); exc_take = 1'b1; exc_take_vec = 8'(v);
        @(negedge clk); exc_take = 1'b0;
    endtask

    task automatic ret();
        @(negedge clk); exc_ret = 1'b1;
        @(negedge clk); exc_ret = 1'b0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(4, d); check("R1 status", d, 32'h0002_0000);
        rd(0, d); check("R1 enable", d, 0);
        rd(1, d); check("R1 pending", d, 0);
        rd(5, d); check("R1 config", d, 0);
        rd(33, d); check("R1 prio", d, 0);
        check("R1 irq_req", {31'b0, irq_req}, 0);

        // R2 hardware pulse latches
        @(negedge clk); irq_in[3] = 1'b1;
        @(negedge clk); irq_in[3] = 1'b0;
        @(negedge clk); rd(1, d); check("R2 pulse held", d, 32'h08);
        wr(2, 32'hFF);

        // R3 set/clear registers; set wins over clear
        wr(1, 32'h05); rd(1, d); check("R3 set", d, 32'h05);
        wr(2, 32'h01); rd(2, d); check("R3 clear", d, 32'h04);
        @(negedge clk); irq_in[2] = 1'b1; bus_addr = 6'd2; bus_wdata = 32'h04; bus_wr = 1'b1;
        @(negedge clk); irq_in[2] = 1'b0; bus_wr = 1'b0;
        rd(1, d); check("R3 set beats clear", d, 32'h04);
        wr(2, 32'hFF);

        // R4 software trigger
        wr(6, 32'd5); rd(1, d); check("R4 trigger id5", d, 32'h20);
        wr(6, 32'd200); rd(1, d); check("R4 id out of range", d, 32'h20);
        wr(6, 32'd8); rd(1, d); check("R4 id equals count", d, 32'h20);
        rd(6, d); check("R4 trigger reads 0", d, 0);
        wr(2, 32'hFF);

        // R5 unprivileged trigger gated by permission bit
        wr(6, 32'd1, 1'b0); rd(1, d); check("R5 unpriv ignored", d, 0);
        wr(5, 32'h100); wr(6, 32'd1, 1'b0); rd(1, d); check("R5 unpriv allowed", d, 32'h02);
        wr(5, 0); wr(2, 32'hFF);

        // R7 any-pending ignores enable; R6 disabled source not chosen
        wr(1, 32'h04); rd(4, d);
        check("R7 any pending", {31'b0, d[16]}, 1);
        check("R6 disabled skipped", {24'b0, irq_vec}, 0);
        wr(2, 32'hFF);

        // R6 winner sweep over all priority pairs
        wr(0, 32'h03);
        for (int pa = 0; pa < 8; pa++)
            for (int pb = 0; pb < 8; pb++) begin
                wr(32, pa); wr(33, pb); wr(1, 32'h03);
                check("R6 winner", {24'b0, irq_vec}, (pa <= pb) ? 16 : 17);
                wr(2, 32'h03);
            end
        wr(0, 32'h02); wr(1, 32'h03); wr(32, 0); wr(33, 7);
        check("R6 enable masks", {24'b0, irq_vec}, 17);
        wr(2, 32'hFF); wr(0, 32'h03);
        check("R6 none pending", {24'b0, irq_vec}, 0);

        // R8 preemption sweep over grouping and priority pairs
        for (int g = 0; g < 4; g++)
            for (int pa = 0; pa < 8; pa++)
                for (int pb = 0; pb < 8; pb++) begin
                    wr(5, g); wr(32, pa); wr(33, pb); wr(1, 32'h01);
                    if (pa == 0 && pb == 0)
                        check("R8 idle request", {31'b0, irq_req}, 1);
                    take(16);
                    wr(1, 32'h02);
                    check("R8 preempt", {31'b0, irq_req}, ((pb >> g) < (pa >> g)) ? 1 : 0);
                    wr(2, 32'h02); ret();
                end
        wr(5, 0);

        // R9 take with same-cycle request -> active and pending
        wr(32, 3); wr(1, 32'h01);
        @(negedge clk); exc_take = 1'b1; exc_take_vec = 8'd16; irq_in[0] = 1'b1;
        @(negedge clk); exc_take = 1'b0; irq_in[0] = 1'b0;
        rd(3, d); check("R9 active", d, 32'h01);
        rd(1, d); check("R9 still pending", d, 32'h01);
        wr(2, 32'h01); rd(1, d); check("R9 take clears pending", d, 0);
        ret();

        // R10 R11 R12 nesting of three handlers
        wr(0, 32'h07); wr(32, 4); wr(33, 2); wr(34, 0);
        take(16); rd(4, d);
        check("R10 run 16", {24'b0, d[7:0]}, 16); check("R12 single", {31'b0, d[17]}, 1);
        take(17); rd(4, d);
        check("R10 run 17", {24'b0, d[7:0]}, 17); check("R12 nested", {31'b0, d[17]}, 0);
        take(18); rd(3, d); check("R10 three active", d, 32'h07);
        ret(); rd(4, d); check("R11 back to 17", {24'b0, d[7:0]}, 17);
        ret(); rd(4, d);
        check("R11 back to 16", {24'b0, d[7:0]}, 16); check("R12 base again", {31'b0, d[17]}, 1);
        ret(); rd(4, d); check("R11 thread", {24'b0, d[7:0]}, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule